// File: doc/BRIEF.md
# Nested Master Control Gate

This block sits beside the bit-logic unit of a controller datapath and decides whether a write that the unit proposes may land as computed. It follows a small command stream: a switch-on command arms the gating, a switch-off command disarms it and empties the nesting history, an enter command records the current logic result as the condition of a new nested region, and a leave command drops the innermost region. The combined power-flow enable is the AND of every recorded region condition. It is forced high whenever the gating is disarmed or no region is open.

Each cycle the block also receives one proposed write together with a kind tag and passes on the write that is actually permitted. When the enable is low, a plain assignment still writes but stores 0. A latching set or reset is dropped entirely. A word transfer still writes, but the word is zero. The region stack holds at most eight conditions. Entering a region while the stack is full, or leaving one while it is empty, raises an error flag in that same cycle and leaves the stack as it was.

Top module: `mcr_gate`

## Requirements
- R1: After a synchronous active-low reset the gating is disarmed and the stack is empty, so `flow_en` is 1 and neither error flag is raised.
- R2: While disarmed, `flow_en` is 1, and enter and leave commands change nothing and raise no flag.
- R3: After a switch-on, each enter command pushes `open_rlo`, and `flow_en` equals the AND of all pushed values. With an empty stack `flow_en` is 1.
- R4: A leave command removes the most recently pushed value, which restores the enable of the enclosing region.
- R5: An enter command with DEPTH (8) entries already stacked raises `ovf_err` in that cycle and leaves the stack unchanged.
- R6: A leave command while armed with an empty stack raises `unf_err` in that cycle and leaves the stack empty.
- R7: A switch-off command empties the stack and disarms the gating. Enter commands are then ignored until the next switch-on.
- R8: Kind 0 (assignment): `out_we` equals `wr_valid`, and `out_bit` is `wr_bit` AND `flow_en`.
- R9: Kinds 1 (set) and 2 (reset): `out_we` is `wr_valid` AND `wr_bit` AND `flow_en`. `out_bit` is 1 for set and 0 for reset.
- R10: Kind 3 (word move): `out_we` equals `wr_valid`, and `out_word` is `wr_word` when `flow_en` is 1 and zero otherwise. `out_word` is zero for the other kinds.
- R11: When several commands arrive in one cycle, switch-off wins over switch-on, switch-on wins over leave, and leave wins over enter. The losing commands have no effect.
- R12: Commands take effect at the next rising clock edge. Write filtering and error flags depend on the state held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_on | input | 1 | Arm the gating |
| cmd_off | input | 1 | Disarm the gating and empty the stack |
| cmd_enter | input | 1 | Push `open_rlo` as a new region condition |
| open_rlo | input | 1 | Logic result carried by an enter command |
| cmd_leave | input | 1 | Pop the innermost region |
| wr_valid | input | 1 | A write is proposed this cycle |
| wr_kind | input | 2 | 0 assign, 1 set, 2 reset, 3 word move |
| wr_bit | input | 1 | Assignment value, or the set/reset condition |
| wr_word | input | WORD_W | Word for a move |
| flow_en | output | 1 | Combined power-flow enable |
| ovf_err | output | 1 | Enter command refused: stack full |
| unf_err | output | 1 | Leave command refused: stack empty |
| out_we | output | 1 | Permitted write strobe |
| out_bit | output | 1 | Permitted bit value |
| out_word | output | WORD_W | Permitted word value |

## Verification
The properties assume that inputs carry no unknown values during clocked operation and that they are stable around the rising edge. The bench therefore drives every input at the falling edge from known values only. No property assumes that commands are mutually exclusive, because the priority order is part of the required behaviour. The random phase deliberately issues overlapping commands, so the overflow and underflow paths are reached under contention as well as in the directed sequences.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  typedef enum logic [1:0] {
    WK_ASSIGN = 2'd0,
    WK_SET    = 2'd1,
    WK_RESET  = 2'd2,
    WK_MOVE   = 2'd3
  } wr_kind_e;

  typedef struct packed {
    logic we;
    logic val;
  } bit_wr_t;

  // Bit-level filtering of one proposed write under the enable.
  function automatic bit_wr_t filter_bit(wr_kind_e kind, logic valid,
                                         logic din, logic en);
    bit_wr_t r;
    r = '0;
    unique case (kind)
      WK_ASSIGN: begin r.we = valid; r.val = din & en; end
      WK_SET:    begin r.we = valid & din & en; r.val = 1'b1; end
      WK_RESET:  begin r.we = valid & din & en; r.val = 1'b0; end
      default:   begin r.we = valid; r.val = 1'b0; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mcr_stack.sv
module mcr_stack #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          on_i,
  input  logic          off_i,
  input  logic          enter_i,
  input  logic          rlo_i,
  input  logic          leave_i,
  output logic          active_o,
  output logic [CW-1:0] depth_o,
  output logic          gate_o,
  output logic          push_o,
  output logic          pop_o,
  output logic          ovf_o,
  output logic          unf_o
);

  logic                active_q;
  logic [CW-1:0]       depth_q;
  logic [DEPTH-1:0]    bits_q;
  logic [DEPTH-1:0]    live_mask;
  logic                full, empty, stack_cmd, want_leave, want_enter;

  assign full       = (depth_q == CW'(DEPTH));
  assign empty      = (depth_q == '0);
  assign stack_cmd  = active_q & ~off_i & ~on_i;
  assign want_leave = stack_cmd & leave_i;
  assign want_enter = stack_cmd & enter_i & ~leave_i;

  assign push_o = want_enter & ~full;
  assign pop_o  = want_leave & ~empty;
  assign ovf_o  = want_enter & full;
  assign unf_o  = want_leave & empty;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      live_mask[i] = (CW'(i) < depth_q);
    end
  end

  assign gate_o   = ~active_q | (&(bits_q | ~live_mask));
  assign active_o = active_q;
  assign depth_o  = depth_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      depth_q  <= '0;
      bits_q   <= '0;
    end else if (off_i) begin
      active_q <= 1'b0;
      depth_q  <= '0;
    end else if (on_i) begin
      active_q <= 1'b1;
    end else if (pop_o) begin
      depth_q <= depth_q - 1'b1;
    end else if (push_o) begin
      bits_q[depth_q[IW-1:0]] <= rlo_i;
      depth_q                 <= depth_q + 1'b1;
    end
  end

endmodule

// File: rtl/mcr_write_filter.sv
module mcr_write_filter
  import mcr_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [1:0]        kind_i,
  input  logic              valid_i,
  input  logic              bit_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              en_i,
  output logic              we_o,
  output logic              bit_o,
  output logic [WORD_W-1:0] word_o
);

  bit_wr_t  bw;
  wr_kind_e kind;

  assign kind = wr_kind_e'(kind_i);

  always_comb begin
    bw     = filter_bit(kind, valid_i, bit_i, en_i);
    we_o   = bw.we;
    bit_o  = bw.val;
    word_o = (kind == WK_MOVE && en_i) ? word_i : '0;
  end

endmodule

// File: rtl/mcr_gate.sv
module mcr_gate #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_on,
  input  logic              cmd_off,
  input  logic              cmd_enter,
  input  logic              open_rlo,
  input  logic              cmd_leave,
  input  logic              wr_valid,
  input  logic [1:0]        wr_kind,
  input  logic              wr_bit,
  input  logic [WORD_W-1:0] wr_word,
  output logic              flow_en,
  output logic              ovf_err,
  output logic              unf_err,
  output logic              out_we,
  output logic              out_bit,
  output logic [WORD_W-1:0] out_word
);

  logic          stk_active;
  logic [CW-1:0] stk_depth;
  logic          push_evt, pop_evt;

  mcr_stack #(.DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .on_i     (cmd_on),
    .off_i    (cmd_off),
    .enter_i  (cmd_enter),
    .rlo_i    (open_rlo),
    .leave_i  (cmd_leave),
    .active_o (stk_active),
    .depth_o  (stk_depth),
    .gate_o   (flow_en),
    .push_o   (push_evt),
    .pop_o    (pop_evt),
    .ovf_o    (ovf_err),
    .unf_o    (unf_err)
  );

  mcr_write_filter #(.WORD_W(WORD_W)) u_filter (
    .kind_i  (wr_kind),
    .valid_i (wr_valid),
    .bit_i   (wr_bit),
    .word_i  (wr_word),
    .en_i    (flow_en),
    .we_o    (out_we),
    .bit_o   (out_bit),
    .word_o  (out_word)
  );

endmodule

// File: rtl/mcr_gate_chk.sv
module mcr_gate_chk #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_off,
  input logic              wr_valid,
  input logic [1:0]        wr_kind,
  input logic              flow_en,
  input logic              ovf_err,
  input logic              unf_err,
  input logic              out_we,
  input logic [WORD_W-1:0] out_word,
  input logic              active,
  input logic [CW-1:0]     depth,
  input logic              push_evt,
  input logic              pop_evt
);

  // R2
  disarmed_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> flow_en);

  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> depth == $past(depth));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_err |=> depth == '0);

  // R7
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_off |=> (depth == '0) && flow_en && !active);

  // R3
  push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> depth == $past(depth) + 1'b1);

  // R4
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> depth == $past(depth) - 1'b1);

  // R11
  one_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_err, unf_err, push_evt, pop_evt}));

  // R9
  latch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_en && wr_valid && (wr_kind == 2'd1 || wr_kind == 2'd2)) |-> !out_we);

  // R10
  move_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_en && wr_kind == 2'd3) |-> out_word == '0);

endmodule

bind mcr_gate mcr_gate_chk #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_off  (cmd_off),
  .wr_valid (wr_valid),
  .wr_kind  (wr_kind),
  .flow_en  (flow_en),
  .ovf_err  (ovf_err),
  .unf_err  (unf_err),
  .out_we   (out_we),
  .out_word (out_word),
  .active   (stk_active),
  .depth    (stk_depth),
  .push_evt (push_evt),
  .pop_evt  (pop_evt)
);

// File: tb/tb_mcr_gate.sv
`timescale 1ns/1ps
module tb_mcr_gate;

  localparam int DEPTH  = 8;
  localparam int WORD_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_on = 0, cmd_off = 0, cmd_enter = 0, open_rlo = 0, cmd_leave = 0;
  logic wr_valid = 0, wr_bit = 0;
  logic [1:0] wr_kind = 0;
  logic [WORD_W-1:0] wr_word = 0;
  logic flow_en, ovf_err, unf_err, out_we, out_bit;
  logic [WORD_W-1:0] out_word;

  always #10 clk = ~clk;

  mcr_gate #(.DEPTH(DEPTH), .WORD_W(WORD_W)) dut (.*);

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference
  bit m_on = 0;
  bit m_stk[$];

  function automatic bit m_flow();
    if (!m_on) return 1'b1;
    foreach (m_stk[i]) if (!m_stk[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit on, bit off, bit ent, bit rlo, bit lv,
                     bit v, int k, bit b, logic [WORD_W-1:0] w);
    bit f, e_ovf, e_unf, e_we, e_bit, busy;
    logic [WORD_W-1:0] e_word;
    @(negedge clk);
    cmd_on = on; cmd_off = off; cmd_enter = ent; open_rlo = rlo; cmd_leave = lv;
    wr_valid = v; wr_kind = 2'(k); wr_bit = b; wr_word = w;
    #5;
    f = m_flow();
    busy = m_on && !off && !on;
    e_unf = busy && lv && m_stk.size() == 0;
    e_ovf = busy && !lv && ent && m_stk.size() == DEPTH;
    case (k)
      0: begin e_we = v; e_bit = b & f; end
      1: begin e_we = v & b & f; e_bit = 1; end
      2: begin e_we = v & b & f; e_bit = 0; end
      default: begin e_we = v; e_bit = 0; end
    endcase
    e_word = (k == 3 && f) ? w : '0;
    chk(tag, "flow_en", flow_en, f);
    chk(tag, "ovf_err", ovf_err, e_ovf);
    chk(tag, "unf_err", unf_err, e_unf);
    chk(tag, "out_we", out_we, e_we);
    chk(tag, "out_bit", out_bit, e_bit);
    chk(tag, "out_word", out_word, e_word);
    if (off) begin m_on = 0; m_stk.delete(); end
    else if (on) m_on = 1;
    else if (m_on && lv) begin if (m_stk.size() > 0) void'(m_stk.pop_back()); end
    else if (m_on && ent) begin if (m_stk.size() < DEPTH) m_stk.push_back(rlo); end
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    idle("R1");
    // R2 disarmed: enter/leave ignored, writes pass
    cyc("R2", 0, 0, 1, 0, 0, 1, 0, 1, '0);
    cyc("R2", 0, 0, 0, 0, 1, 1, 3, 0, 16'h1234);
    idle("R2");
    // R3 arm and nest
    cyc("R3", 1, 0, 0, 0, 0, 0, 0, 0, '0);
    cyc("R3", 0, 0, 1, 1, 0, 0, 0, 0, '0);
    cyc("R12", 0, 0, 1, 0, 0, 1, 0, 1, '0);   // flow still 1 this cycle
    // gate now low: R8, R9, R10
    cyc("R8", 0, 0, 0, 0, 0, 1, 0, 1, '0);
    cyc("R9", 0, 0, 0, 0, 0, 1, 1, 1, '0);
    cyc("R9", 0, 0, 0, 0, 0, 1, 2, 1, '0);
    cyc("R10", 0, 0, 0, 0, 0, 1, 3, 0, 16'hA5C3);
    // R4 leave restores outer enable
    cyc("R4", 0, 0, 0, 0, 1, 0, 0, 0, '0);
    cyc("R9", 0, 0, 0, 0, 0, 1, 1, 1, '0);
    cyc("R9", 0, 0, 0, 0, 0, 1, 2, 1, '0);
    cyc("R9", 0, 0, 0, 0, 0, 1, 1, 0, '0);
    cyc("R10", 0, 0, 0, 0, 0, 1, 3, 0, 16'h5A3C);
    cyc("R8", 0, 0, 0, 0, 0, 0, 0, 1, '0);
    // R6 underflow
    cyc("R4", 0, 0, 0, 0, 1, 0, 0, 0, '0);
    cyc("R6", 0, 0, 0, 0, 1, 0, 0, 0, '0);
    idle("R6");
    // R5 fill to depth then overflow with a 0 that must not land
    for (int i = 0; i < DEPTH; i++) cyc("R3", 0, 0, 1, 1, 0, 0, 0, 0, '0);
    cyc("R5", 0, 0, 1, 0, 0, 0, 0, 0, '0);
    cyc("R5", 0, 0, 0, 0, 0, 1, 0, 1, '0);
    cyc("R4", 0, 0, 0, 0, 1, 0, 0, 0, '0);
    cyc("R3", 0, 0, 1, 0, 0, 0, 0, 0, '0);
    idle("R3");
    // R7 switch-off clears, enter ignored until switch-on
    cyc("R7", 0, 1, 0, 0, 0, 0, 0, 0, '0);
    cyc("R7", 0, 0, 1, 0, 0, 1, 3, 0, 16'h00FF);
    cyc("R7", 1, 0, 0, 0, 0, 0, 0, 0, '0);
    cyc("R7", 0, 0, 0, 0, 1, 0, 0, 0, '0);
    // R11 priority
    cyc("R11", 0, 0, 1, 0, 1, 0, 0, 0, '0);   // leave wins: underflow
    cyc("R11", 1, 0, 1, 0, 0, 0, 0, 0, '0);   // switch-on masks enter
    idle("R11");
    cyc("R11", 0, 0, 1, 0, 0, 0, 0, 0, '0);
    cyc("R11", 1, 1, 1, 1, 0, 0, 0, 0, '0);   // switch-off wins
    idle("R11");
    // mixed random traffic, commands may overlap
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc("R3", r < 2, r >= 2 && r < 4, ($urandom_range(0, 9) < 4),
          $urandom_range(0, 4) != 0, ($urandom_range(0, 9) < 3),
          $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 1),
          WORD_W'($urandom));
    end
    finish_run();
  end

endmodule